// File: doc/BRIEF.md
# Scrambled NRZI Serial Word Encoder

This block turns a stream of 10-bit parallel words into a serial bit stream running at one bit per clock, which is ten bits per word period. It runs entirely in the bit-clock domain: an internal slot counter takes the place of a separate word clock, and it asks for a new word once every ten bit periods. Each word is shifted out least significant bit first.

In the normal mode, every serial bit passes through a self-synchronizing scrambler with generator x^9+x^4+1. The scrambled bit is then NRZI coded with x+1, so a one becomes a level change and a zero holds the level. A receiver can recover the data with the matching inverse stages and no alignment to the transmitter's state.

A mode select sends the unscrambled serial bits straight to the output instead. A lock input qualifies the bit clock. While lock is low, the output is forced to zero and the whole pipeline freezes. When lock returns, the stream resumes where it stopped, so no bit is lost or repeated.

Word input rules (valid/ready):
- A word is taken on a clock edge at which both `word_valid` and `word_ready` are high.
- `word_ready` is high for exactly one cycle in every ten locked cycles, and never while lock is low.
- The source may raise `word_valid` at any time, and it must keep `word_data` steady until the word is taken.
- If no valid word is waiting when the shifter needs one, the block loads the parameter `IDLE_WORD` and sends it instead. The block never stalls on the source.

Top module: `serial_word_encoder`

## Requirements
- R1: `word_ready` is high only while `lock_ok` is high. While lock is held high it is high in one cycle of every ten. The first such cycle is the first cycle after reset.
- R2: When a word is taken at clock edge E and `bypass_sel` is high, bit i of that word (bit 0 first) appears on `sdo` after edge E+1+i.
- R3: The scrambled bit is s(n) = d(n) XOR s(n-9) XOR s(n-4). Here d(n) is the serial bit, and the scrambled history is all zero after reset.
- R4: The NRZI level is y(n) = s(n) XOR y(n-1), with a level of 0 after reset. A scrambled one toggles the line and a zero holds it.
- R5: With `bypass_sel` low (value 0 = scrambled mode), `sdo` carries y(n) one clock after bit n is processed. Descrambling the output, first with x+1 and then with x^9+x^4+1, returns the input words.
- R6: With `bypass_sel` high (value 1 = raw mode), `sdo` carries the unscrambled serial bit, registered once.
- R7: While `lock_ok` is low, `sdo` is 0 after the next edge and the slot counter, shift register, scrambler history and NRZI level all hold. After lock returns, the locked-edge output sequence continues as if the gap had not occurred.
- R8: If `word_valid` is low in a cycle where `word_ready` is high, the word `IDLE_WORD` is serialized in place of data.
- R9: After reset, `sdo` is 0, and `word_ready` equals `lock_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_ok | input | 1 | High when the bit clock is valid; low freezes the pipeline and zeroes the output |
| bypass_sel | input | 1 | 0 = scrambled NRZI output, 1 = raw serialized bits |
| word_valid | input | 1 | Source has a word on `word_data` |
| word_ready | output | 1 | Block takes the word at this edge |
| word_data | input | WORD_W (10) | Parallel word, bit 0 sent first |
| sdo | output | 1 | Registered serial data output |

## Verification
The assertions check, on every cycle, the local rules of each stage:
- the slot counter steps by one and the shift register loads the offered word or the idle word at the slot boundary;
- the scrambler history shifts by one position;
- the NRZI level toggles only on a scrambled one;
- everything holds while lock is low;
- the output register follows the raw bit or the NRZI level, depending on the mode, and is zero while unlocked.

Only the bench scenarios can show the end-to-end properties:
- bit order and the exact latency from word acceptance to output;
- the ten-cycle ready cadence;
- that a separate descrambler recovers every word, including across a lock dropout.

// File: rtl/swe_pkg.sv
package swe_pkg;

  // Output path selection driven by the mode pin.
  typedef enum logic {
    MODE_SCRAMBLED = 1'b0,
    MODE_RAW       = 1'b1
  } out_mode_e;

  // Default geometry of the serializer and the scrambler generator.
  localparam int unsigned DEF_WORD_W    = 10;
  localparam int unsigned DEF_LONG_TAP  = 9;
  localparam int unsigned DEF_SHORT_TAP = 4;

endpackage

// File: rtl/swe_word_shifter.sv
module swe_word_shifter #(
  parameter int unsigned WORD_W = swe_pkg::DEF_WORD_W,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              bit_out
);

  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_SLOT = CW'(WORD_W - 1);

  logic [CW-1:0]     slot_q;
  logic [WORD_W-1:0] shreg_q;
  logic              at_last;

  assign at_last  = (slot_q == LAST_SLOT);
  assign in_ready = advance && at_last;
  assign bit_out  = shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= LAST_SLOT;
      shreg_q <= '0;
    end else if (advance) begin
      if (at_last) begin
        slot_q  <= '0;
        shreg_q <= in_valid ? in_data : IDLE_WORD;
      end else begin
        slot_q  <= slot_q + 1'b1;
        shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
      end
    end
  end

  // R1: slot counter advances one step per locked cycle inside a word
  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_last) |=> (slot_q == $past(slot_q) + 1'b1));

  // R2: accepted word lands in the shift register
  assert_word_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (shreg_q == $past(in_data)));

  // R8: idle word fills an empty slot
  assert_idle_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> (shreg_q == IDLE_WORD));

  // R7: nothing moves while unlocked
  assert_shift_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(slot_q) && $stable(shreg_q)));

endmodule

// File: rtl/swe_scrambler.sv
module swe_scrambler #(
  parameter int unsigned LONG_TAP  = swe_pkg::DEF_LONG_TAP,
  parameter int unsigned SHORT_TAP = swe_pkg::DEF_SHORT_TAP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic din,
  output logic dout
);

  // hist_q[k] holds the scrambled bit produced k+1 steps ago.
  logic [LONG_TAP-1:0] hist_q;

  assign dout = din ^ hist_q[LONG_TAP-1] ^ hist_q[SHORT_TAP-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (advance) begin
      hist_q <= {hist_q[LONG_TAP-2:0], dout};
    end
  end

  // R3: history is a pure delay line of scrambled bits
  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (hist_q[LONG_TAP-1:1] == $past(hist_q[LONG_TAP-2:0])));

  // R7: scrambler state retained while unlocked
  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(hist_q));

endmodule

// File: rtl/swe_nrzi.sv
module swe_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic din,
  output logic level_next,
  output logic level
);

  logic level_q;

  assign level      = level_q;
  assign level_next = level_q ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else if (advance) begin
      level_q <= level_next;
    end
  end

  // R4: a scrambled one flips the line level
  assert_one_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && din) |=> (level_q != $past(level_q)));

  // R4: a scrambled zero keeps the line level
  assert_zero_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !din) |=> $stable(level_q));

  // R7: NRZI level retained while unlocked
  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(level_q));

endmodule

// File: rtl/serial_word_encoder.sv
module serial_word_encoder #(
  parameter int unsigned WORD_W    = swe_pkg::DEF_WORD_W,
  parameter int unsigned LONG_TAP  = swe_pkg::DEF_LONG_TAP,
  parameter int unsigned SHORT_TAP = swe_pkg::DEF_SHORT_TAP,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_ok,
  input  logic              bypass_sel,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              sdo
);

  import swe_pkg::*;

  out_mode_e mode;
  logic      raw_bit;
  logic      scr_bit;
  logic      nrzi_next;
  logic      nrzi_level;
  logic      sdo_q;

  assign mode = out_mode_e'(bypass_sel);

  swe_word_shifter #(
    .WORD_W    (WORD_W),
    .IDLE_WORD (IDLE_WORD)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (lock_ok),
    .in_valid (word_valid),
    .in_ready (word_ready),
    .in_data  (word_data),
    .bit_out  (raw_bit)
  );

  swe_scrambler #(
    .LONG_TAP  (LONG_TAP),
    .SHORT_TAP (SHORT_TAP)
  ) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (lock_ok),
    .din     (raw_bit),
    .dout    (scr_bit)
  );

  swe_nrzi u_nrzi (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (lock_ok),
    .din        (scr_bit),
    .level_next (nrzi_next),
    .level      (nrzi_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (!lock_ok) begin
      sdo_q <= 1'b0;
    end else if (mode == MODE_RAW) begin
      sdo_q <= raw_bit;
    end else begin
      sdo_q <= nrzi_next;
    end
  end

  assign sdo = sdo_q;

  // R7: output forced low while the bit clock is not valid
  assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |=> !sdo);

  // R6: raw mode forwards the serializer bit
  assert_raw_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ok && bypass_sel) |=> (sdo == $past(raw_bit)));

  // R5: scrambled mode forwards the NRZI line level
  assert_nrzi_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ok && !bypass_sel) |=> (sdo == nrzi_level));

  // R1: no word is requested while unlocked
  assert_ready_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |-> !word_ready);

endmodule

// File: tb/serial_word_encoder_test.sv
module serial_word_encoder_test;

  localparam int W = 10;
  localparam logic [W-1:0] IDLE = 10'h2A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_ok = 1'b1;
  logic bypass_sel = 1'b0;
  logic word_valid = 1'b0;
  logic word_ready;
  logic [W-1:0] word_data = '0;
  logic sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] words [8];
  logic lobs [256];   // sdo after each locked edge
  logic rdy [256];    // word_ready before each edge
  int nl;

  always #5 clk = ~clk;

  serial_word_encoder #(.IDLE_WORD(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .bypass_sel(bypass_sel),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .sdo(sdo)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; lock_ok = 1'b1; word_valid = 1'b0; bypass_sel = mode;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // Runs ncyc cycles, streaming nwords back to back, lock low in [lo, lo+len).
  task automatic run(input int ncyc, input int nwords, input int lo, input int len);
    int k = 0;
    nl = 0;
    for (int c = 0; c < ncyc; c++) begin
      bit acc;
      lock_ok = !(c >= lo && c < lo + len);
      word_valid = (k < nwords);
      word_data = (k < nwords) ? words[k] : '0;
      #1;
      acc = word_valid && word_ready;
      rdy[c] = word_ready;
      if (!lock_ok) check(word_ready == 1'b0, "R1", "ready while unlocked", word_ready, 0);
      @(posedge clk);
      #1;
      if (acc) k++;
      if (lock_ok) begin
        lobs[nl] = sdo;
        nl++;
      end else begin
        check(sdo == 1'b0, "R7", "sdo while unlocked", sdo, 0);
      end
    end
    lock_ok = 1'b1;
    word_valid = 1'b0;
  endtask

  // Bit processed at locked edge j: a zero placeholder, then the words LSB first, then idle.
  function automatic logic exp_bit(input int j, input int nwords);
    int i;
    if (j == 0) return 1'b0;
    i = j - 1;
    if (i < W * nwords) return words[i / W][i % W];
    return IDLE[i % W];
  endfunction

  task automatic check_scrambled(input int nwords, input string tag);
    logic s [256];
    logic rs [256];
    logic b [256];
    logic prev_y = 1'b0;
    int bad = 0;
    int first_bad = -1;
    for (int j = 0; j < nl; j++) begin
      logic s9, s4, y;
      s9 = (j >= 9) ? s[j-9] : 1'b0;
      s4 = (j >= 4) ? s[j-4] : 1'b0;
      s[j] = exp_bit(j, nwords) ^ s9 ^ s4;
      y = s[j] ^ prev_y;
      prev_y = y;
      if (lobs[j] !== y) begin
        bad++;
        if (first_bad < 0) first_bad = j;
      end
    end
    check(bad == 0, "R3 R4", {tag, " forward model mismatches"}, bad, 0);
    for (int j = 0; j < nl; j++) begin
      logic r9, r4;
      rs[j] = lobs[j] ^ ((j > 0) ? lobs[j-1] : 1'b0);
      r9 = (j >= 9) ? rs[j-9] : 1'b0;
      r4 = (j >= 4) ? rs[j-4] : 1'b0;
      b[j] = rs[j] ^ r9 ^ r4;
    end
    for (int w = 0; w < nwords; w++) begin
      logic [W-1:0] got;
      for (int i = 0; i < W; i++) got[i] = b[1 + W*w + i];
      check(got == words[w], "R5", {tag, " descrambled word"}, int'(got), int'(words[w]));
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check(sdo == 1'b0, "R9", "sdo after reset", sdo, 0);
    check(word_ready == 1'b1, "R9", "ready after reset with lock", word_ready, 1);
    lock_ok = 1'b0;
    #1;
    check(word_ready == 1'b0, "R1", "ready drops with lock", word_ready, 0);
    lock_ok = 1'b1;
  endtask

  task automatic t_cadence_idle;
    int cnt = 0;
    int bad = 0;
    do_reset(1'b1);
    run(40, 0, 1000, 0);
    for (int c = 0; c < 40; c++) begin
      if (rdy[c]) cnt++;
      if (rdy[c] !== ((c % W) == 0)) bad++;
    end
    check(cnt == 4, "R1", "ready pulses in 40 cycles", cnt, 4);
    check(bad == 0, "R1", "ready off-cadence cycles", bad, 0);
    bad = 0;
    for (int j = 1; j < nl; j++) if (lobs[j] !== IDLE[(j-1) % W]) bad++;
    check(bad == 0, "R8", "idle word bit mismatches", bad, 0);
  endtask

  task automatic t_raw;
    int bad = 0;
    int fj = -1;
    do_reset(1'b1);
    run(70, 6, 1000, 0);
    for (int j = 0; j < nl; j++) begin
      if (lobs[j] !== exp_bit(j, 6)) begin
        bad++;
        if (fj < 0) fj = j;
      end
    end
    check(bad == 0, "R2 R6", "raw bit mismatches (LSB first, edge E+1+i)", bad, 0);
    check(lobs[1] == words[0][0], "R2", "first bit is word0 bit0", lobs[1], words[0][0]);
    check(lobs[10] == words[0][9], "R2", "tenth bit is word0 bit9", lobs[10], words[0][9]);
  endtask

  task automatic t_scrambled;
    do_reset(1'b0);
    run(90, 8, 1000, 0);
    check_scrambled(8, "continuous");
  endtask

  task automatic t_lock_gap;
    do_reset(1'b0);
    run(97, 8, 23, 7);
    check(nl == 90, "R7", "locked edge count", nl, 90);
    check_scrambled(8, "with lock gap");
  endtask

  initial begin
    words[0] = 10'h3FF; words[1] = 10'h000; words[2] = 10'h155; words[3] = 10'h2AA;
    words[4] = 10'h001; words[5] = 10'h200; words[6] = 10'h123; words[7] = 10'h3C0;
    t_reset();
    t_cadence_idle();
    t_raw();
    t_scrambled();
    t_lock_gap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule